// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor Core

This block is a 32-bit processor that completes one instruction per clock. In each cycle it fetches a word from an internal instruction array at the program counter and splits it into fixed fields. It reads two source registers and then computes an arithmetic result, a shift, a comparison or a memory address. For loads and stores it accesses an internal data array. The result is written back before the next edge. It supports add, sub, slt, sll, srl, jr, addi, lw, sw, beq, bne and j. Only whole 32-bit words are transferred.

Programs and initial data are placed into the two arrays through a small loader port, which writes only while reset is held. After a run, any register and any data word can be read through two combinational peek ports. The program counter and a sticky fault flag are also visible as outputs.

Top module: `mini_sc_cpu`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) sets the program counter to 0, clears align_fault and clears all 32 registers.
- R2: An instruction that does not transfer control advances the program counter by 4 after it executes. The fetch index is pc[IAW+1:2].
- R3: Instruction fields, from MSB to LSB, are: op[31:26], rs[25:21], rt[20:16], rd[15:11], shamt[10:6] and funct[5:0]. With op 0, funct 32 writes rs+rt to rd and funct 34 writes rs-rt to rd.
- R4: With op 0, funct 42 writes 1 to rd when rs is less than rt as signed values, and 0 otherwise. Funct 0 writes rt shifted left by shamt into rd. Funct 2 writes rt shifted right logically by shamt into rd.
- R5: Op 8 (addi) writes rs plus the sign-extended imm[15:0] into rt.
- R6: Op 35 loads the data word at rs+sext(imm) into rt. Op 43 stores rt there. The word index is address bits [DAW+1:2].
- R7: Register 0 always reads as zero, and writes to it are discarded.
- R8: Op 4 (beq) branches when rs equals rt, and op 5 (bne) branches when they differ. The target is pc+4+(sext(imm)<<2), and backward offsets are allowed.
- R9: Op 2 (j) jumps to {pc+4[31:28], target[25:0], 2'b00}. With op 0, funct 8 (jr) loads the program counter from rs.
- R10: A load or store whose address has nonzero bits [1:0], or lies beyond the data array, sets align_fault. The fault stays set until reset, and that access writes neither memory nor any register.
- R11: The loader port (ld_sel 0 for instruction array, 1 for data array) writes only while rst is high. Otherwise it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ld_we | input | 1 | Loader write strobe |
| ld_sel | input | 1 | Loader target: 0 instruction array, 1 data array |
| ld_addr | input | IAW | Loader word index |
| ld_data | input | 32 | Loader write word |
| peek_reg | input | 5 | Register number to observe |
| peek_reg_val | output | 32 | Value of the observed register |
| peek_word | input | DAW | Data word index to observe |
| peek_word_val | output | 32 | Value of the observed data word |
| pc_out | output | 32 | Current program counter |
| align_fault | output | 1 | Sticky bad-address flag |

## Verification
Two things can happen in the same cycle: a store's address check and its write to the data array. Both are decided from the same effective address. The test program ends with a misaligned load followed by a misaligned store to word 0. The bench checks that the flag is clear after exactly 31 instructions and set one cycle later. It then judges the store by reading back word 0, which must still be zero, and the load's destination register, which must be unchanged.

// File: rtl/mini_sc_cpu.sv
module mini_sc_cpu #(
  parameter int IMEM_DEPTH = 64,
  parameter int DMEM_DEPTH = 64,
  localparam int IAW = $clog2(IMEM_DEPTH),
  localparam int DAW = $clog2(DMEM_DEPTH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ld_we,
  input  logic           ld_sel,
  input  logic [IAW-1:0] ld_addr,
  input  logic [31:0]    ld_data,
  input  logic [4:0]     peek_reg,
  output logic [31:0]    peek_reg_val,
  input  logic [DAW-1:0] peek_word,
  output logic [31:0]    peek_word_val,
  output logic [31:0]    pc_out,
  output logic           align_fault
);

  localparam logic [5:0] OP_RTYPE = 6'd0,  OP_J   = 6'd2,  OP_BEQ = 6'd4,
                         OP_BNE   = 6'd5,  OP_ADDI = 6'd8, OP_LW  = 6'd35,
                         OP_SW    = 6'd43;
  localparam logic [5:0] FN_SLL = 6'd0, FN_SRL = 6'd2, FN_JR = 6'd8,
                         FN_ADD = 6'd32, FN_SUB = 6'd34, FN_SLT = 6'd42;

  logic [31:0] imem [IMEM_DEPTH];
  logic [31:0] dmem [DMEM_DEPTH];
  logic [31:0] rf   [32];

  logic [31:0] pc, pc4, instr, nxt_pc;
  logic [31:0] rs_val, rt_val, imm_sx, eff_addr, br_tgt, rd_word;
  logic [5:0]  op, fn;
  logic [4:0]  rs, rt, rd, sh;
  logic        bad_addr, is_ctrl, mem_acc, rf_we, dm_we;
  logic [4:0]  rf_wa;
  logic [31:0] rf_wd;

  assign instr  = imem[pc[IAW+1:2]];
  assign op     = instr[31:26];
  assign rs     = instr[25:21];
  assign rt     = instr[20:16];
  assign rd     = instr[15:11];
  assign sh     = instr[10:6];
  assign fn     = instr[5:0];
  assign imm_sx = {{16{instr[15]}}, instr[15:0]};

  assign rs_val = (rs == 5'd0) ? 32'd0 : rf[rs];
  assign rt_val = (rt == 5'd0) ? 32'd0 : rf[rt];

  assign pc4      = pc + 32'd4;
  assign br_tgt   = pc4 + {imm_sx[29:0], 2'b00};
  assign eff_addr = rs_val + imm_sx;
  assign bad_addr = (eff_addr[1:0] != 2'b00) || (eff_addr[31:DAW+2] != '0);
  assign rd_word  = dmem[eff_addr[DAW+1:2]];

  always_comb begin
    nxt_pc  = pc4;
    is_ctrl = 1'b0;
    mem_acc = 1'b0;
    rf_we   = 1'b0;
    rf_wa   = rd;
    rf_wd   = 32'd0;
    dm_we   = 1'b0;
    case (op)
      OP_RTYPE: begin
        rf_we = 1'b1;
        case (fn)
          FN_ADD: rf_wd = rs_val + rt_val;
          FN_SUB: rf_wd = rs_val - rt_val;
          FN_SLT: rf_wd = {31'd0, $signed(rs_val) < $signed(rt_val)};
          FN_SLL: rf_wd = rt_val << sh;
          FN_SRL: rf_wd = rt_val >> sh;
          FN_JR: begin
            rf_we   = 1'b0;
            is_ctrl = 1'b1;
            nxt_pc  = rs_val;
          end
          default: rf_we = 1'b0;
        endcase
      end
      OP_ADDI: begin
        rf_we = 1'b1;
        rf_wa = rt;
        rf_wd = rs_val + imm_sx;
      end
      OP_LW: begin
        mem_acc = 1'b1;
        rf_we   = !bad_addr;
        rf_wa   = rt;
        rf_wd   = rd_word;
      end
      OP_SW: begin
        mem_acc = 1'b1;
        dm_we   = !bad_addr;
      end
      OP_BEQ: begin
        is_ctrl = 1'b1;
        if (rs_val == rt_val) nxt_pc = br_tgt;
      end
      OP_BNE: begin
        is_ctrl = 1'b1;
        if (rs_val != rt_val) nxt_pc = br_tgt;
      end
      OP_J: begin
        is_ctrl = 1'b1;
        nxt_pc  = {pc4[31:28], instr[25:0], 2'b00};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc          <= 32'd0;
      align_fault <= 1'b0;
      for (int i = 0; i < 32; i++) rf[i] <= 32'd0;
    end else begin
      pc <= nxt_pc;
      if (mem_acc && bad_addr) align_fault <= 1'b1;
      if (rf_we && rf_wa != 5'd0) rf[rf_wa] <= rf_wd;
    end
  end

  always_ff @(posedge clk) begin
    if (rst && ld_we && !ld_sel) imem[ld_addr] <= ld_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      if (ld_we && ld_sel) dmem[ld_addr[DAW-1:0]] <= ld_data;
    end else if (dm_we) begin
      dmem[eff_addr[DAW+1:2]] <= rt_val;
    end
  end

  assign pc_out        = pc;
  assign peek_reg_val  = (peek_reg == 5'd0) ? 32'd0 : rf[peek_reg];
  assign peek_word_val = dmem[peek_word];

endmodule

// File: rtl/mini_sc_cpu_chk.sv
module mini_sc_cpu_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] pc_out,
  input logic        align_fault,
  input logic [4:0]  peek_reg,
  input logic [31:0] peek_reg_val,
  input logic        is_ctrl,
  input logic        mem_acc,
  input logic [31:0] eff_addr
);

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (pc_out == 32'd0 && !align_fault));

  a_r2_seq_advance: assert property (@(posedge clk) disable iff (rst)
    (!is_ctrl) |=> (pc_out == $past(pc_out) + 32'd4));

  a_r10_fault_sticky: assert property (@(posedge clk) disable iff (rst)
    align_fault |=> align_fault);

  a_r10_misaligned_flags: assert property (@(posedge clk) disable iff (rst)
    (mem_acc && eff_addr[1:0] != 2'b00) |=> align_fault);

  a_r7_zero_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (peek_reg == 5'd0) |-> (peek_reg_val == 32'd0));

endmodule

bind mini_sc_cpu mini_sc_cpu_chk chk_i (
  .clk(clk),
  .rst(rst),
  .pc_out(pc_out),
  .align_fault(align_fault),
  .peek_reg(peek_reg),
  .peek_reg_val(peek_reg_val),
  .is_ctrl(is_ctrl),
  .mem_acc(mem_acc),
  .eff_addr(eff_addr)
);

// File: tb/mini_sc_cpu_tb.sv
`timescale 1ns/1ps
module mini_sc_cpu_tb_top;
  localparam int IMEM_DEPTH = 64;
  localparam int DMEM_DEPTH = 64;
  localparam int IAW = $clog2(IMEM_DEPTH);
  localparam int DAW = $clog2(DMEM_DEPTH);
  localparam int PROG_LEN = 30;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           ld_we = 1'b0;
  logic           ld_sel = 1'b0;
  logic [IAW-1:0] ld_addr = '0;
  logic [31:0]    ld_data = '0;
  logic [4:0]     peek_reg = '0;
  logic [31:0]    peek_reg_val;
  logic [DAW-1:0] peek_word = '0;
  logic [31:0]    peek_word_val;
  logic [31:0]    pc_out;
  logic           align_fault;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mini_sc_cpu #(.IMEM_DEPTH(IMEM_DEPTH), .DMEM_DEPTH(DMEM_DEPTH)) dut_i (
    .clk(clk), .rst(rst), .ld_we(ld_we), .ld_sel(ld_sel), .ld_addr(ld_addr),
    .ld_data(ld_data), .peek_reg(peek_reg), .peek_reg_val(peek_reg_val),
    .peek_word(peek_word), .peek_word_val(peek_word_val),
    .pc_out(pc_out), .align_fault(align_fault)
  );

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, int sh, int fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'(sh), 6'(fn)};
  endfunction
  function automatic logic [31:0] enc_i(int op, int rs, int rt, int imm);
    return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
  endfunction
  function automatic logic [31:0] enc_j(int op, int tgt);
    return {6'(op), 26'(tgt)};
  endfunction

  // expected register file after the run: {index, value}
  localparam logic [36:0] EXP_REGS [18] = '{
    {5'd0,  32'h0000_0000},  // R7 write to r0 discarded
    {5'd1,  32'h0000_0005},  // R5
    {5'd2,  32'hFFFF_FFFD},  // R5 negative immediate
    {5'd3,  32'h0000_0002},  // R3 add
    {5'd4,  32'hFFFF_FFF8},  // R3 sub
    {5'd5,  32'h0000_0001},  // R4 slt signed true
    {5'd6,  32'h0000_0000},  // R4 slt false
    {5'd7,  32'h0000_0050},  // R4 sll
    {5'd8,  32'h0000_000F},  // R4 srl logical
    {5'd9,  32'h0000_0005},  // R6 lw
    {5'd10, 32'hFFFF_FFF8},  // R6 lw after negative-offset sw
    {5'd11, 32'h0000_0000},  // R8 skipped by taken beq
    {5'd12, 32'h0000_0007},  // R8 not-taken bne falls through
    {5'd13, 32'h0000_0050},  // R9 jr source
    {5'd15, 32'h0000_0000},  // R9 R8 skipped by jr and bne
    {5'd16, 32'h0000_7FFF},  // R5 max positive immediate
    {5'd17, 32'h0000_0000},  // R10 misaligned lw writes nothing
    {5'd18, 32'h0000_0005}   // R8 backward loop count
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_word(logic sel, int idx, logic [31:0] val);
    @(negedge clk);
    ld_we = 1'b1; ld_sel = sel; ld_addr = IAW'(idx); ld_data = val;
    @(posedge clk);
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  logic [31:0] prog [PROG_LEN];

  initial begin
    prog[0]  = enc_i(8, 0, 1, 5);
    prog[1]  = enc_i(8, 0, 2, -3);
    prog[2]  = enc_r(1, 2, 3, 0, 32);
    prog[3]  = enc_r(2, 1, 4, 0, 34);
    prog[4]  = enc_r(2, 1, 5, 0, 42);
    prog[5]  = enc_r(1, 2, 6, 0, 42);
    prog[6]  = enc_r(0, 1, 7, 4, 0);
    prog[7]  = enc_r(0, 2, 8, 28, 2);
    prog[8]  = enc_i(43, 0, 1, 8);
    prog[9]  = enc_i(43, 7, 4, -4);
    prog[10] = enc_i(35, 0, 9, 8);
    prog[11] = enc_i(35, 0, 10, 76);
    prog[12] = enc_r(1, 1, 0, 0, 32);
    prog[13] = enc_i(4, 1, 9, 1);
    prog[14] = enc_i(8, 0, 11, 99);
    prog[15] = enc_i(5, 1, 1, 1);
    prog[16] = enc_i(8, 0, 12, 7);
    prog[17] = enc_i(8, 0, 13, 80);
    prog[18] = enc_r(13, 0, 0, 0, 8);
    prog[19] = enc_i(8, 0, 15, 55);
    prog[20] = enc_i(5, 1, 2, 2);
    prog[21] = enc_i(8, 0, 15, 1);
    prog[22] = enc_i(8, 0, 15, 2);
    prog[23] = enc_i(4, 3, 1, 5);
    prog[24] = enc_i(8, 0, 16, 32'h7FFF);
    prog[25] = enc_i(8, 18, 18, 1);
    prog[26] = enc_i(5, 18, 1, -2);
    prog[27] = enc_i(35, 0, 17, 5);
    prog[28] = enc_i(43, 0, 1, 2);
    prog[29] = enc_j(2, 29);

    repeat (2) @(posedge clk);
    for (int i = 0; i < IMEM_DEPTH; i++)
      load_word(1'b0, i, (i < PROG_LEN) ? prog[i] : 32'd0);
    for (int i = 0; i < DMEM_DEPTH; i++)
      load_word(1'b1, i, 32'd0);

    chk("R1 reset pc", pc_out, 32'd0);
    chk("R1 reset fault", {31'd0, align_fault}, 32'd0);

    @(negedge clk);
    rst = 1'b0;
    repeat (31) @(posedge clk);
    @(negedge clk);
    chk("R8 R2 pc after 31 instructions", pc_out, 32'd108);
    chk("R10 fault clear before bad access", {31'd0, align_fault}, 32'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R10 fault set by misaligned lw", {31'd0, align_fault}, 32'd1);
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk("R9 j holds pc at self", pc_out, 32'd116);
    chk("R10 fault sticky", {31'd0, align_fault}, 32'd1);

    for (int k = 0; k < 18; k++) begin
      peek_reg = EXP_REGS[k][36:32];
      #1;
      chk($sformatf("R3-table reg%0d", EXP_REGS[k][36:32]), peek_reg_val, EXP_REGS[k][31:0]);
    end

    peek_word = DAW'(2);  #1; chk("R6 sw word 2", peek_word_val, 32'd5);
    peek_word = DAW'(19); #1; chk("R6 sw negative offset word 19", peek_word_val, 32'hFFFF_FFF8);
    peek_word = DAW'(0);  #1; chk("R10 misaligned sw left word 0", peek_word_val, 32'd0);
    peek_word = DAW'(1);  #1; chk("R10 word 1 untouched", peek_word_val, 32'd0);

    @(negedge clk);
    ld_we = 1'b1; ld_sel = 1'b1; ld_addr = IAW'(2); ld_data = 32'hDEAD_BEEF;
    @(posedge clk);
    @(negedge clk);
    ld_we = 1'b0;
    peek_word = DAW'(2); #1;
    chk("R11 loader ignored while running", peek_word_val, 32'd5);

    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R1 re-reset pc", pc_out, 32'd0);
    chk("R1 re-reset fault", {31'd0, align_fault}, 32'd0);
    peek_reg = 5'd1; #1;
    chk("R1 re-reset clears r1", peek_reg_val, 32'd0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule